// File: doc/BRIEF.md
# Ultra DMA Host Receive Controller

This block is the host side of a data-in burst on an Ultra DMA link: the device drives data and a strobe, and the host takes in the data. The controller watches the device request and strobe lines, and drives the host ready and STOP lines. Each change of the strobe level, rising or falling, stores one data word into a local buffer. Software-side logic loads a word count before the command runs. It then reads words out of the buffer, and it may ask for an early end through a one-cycle request.

All device inputs go through two register stages before use, so data and strobe stay aligned. The controller lowers ready when the buffer nears full, with enough headroom for words already in flight. It treats a strobe that stops toggling as a pause by the sender, not as an end. It runs both ways of ending a burst. If the host ends the burst, ready drops first, a programmable wait elapses, and then STOP rises until the device withdraws its request. If the device ends the burst by withdrawing its request, the host confirms with STOP. An end with words outstanding leaves the count in place, so a later burst can finish the command.

Top module: `udma_rx_ctrl`

## Requirements
- R1: After reset host_ready, host_stop, xfer_done and early_end are 0, buf_empty is 1 and words_left is 0.
- R2: During a burst host_ready is 1 only while the buffer's free entries exceed cfg_thresh. It falls when free entries drop to cfg_thresh or below, and rises again once reads free space.
- R3: The strobe level present when a burst opens is not data. Every later change of dev_strobe, in either direction, stores one dev_data word, and the words come out at buf_data in arrival order.
- R4: While dev_rq stays 1 and dev_strobe does not change, host_ready stays 1 and host_stop stays 0 for as long as the stall lasts.
- R5: When end_req is pulsed or words_left reaches 0, host_ready falls first. host_stop then rises exactly cfg_wait+1 clocks after host_ready fell, stays 1 while dev_rq is 1, and falls after dev_rq goes to 0.
- R6: When dev_rq falls during a burst before the host has asserted STOP, host_stop goes to 1 to confirm, then back to 0, and the controller returns to idle.
- R7: cfg_load in idle sets words_left to cfg_words. Each stored word lowers words_left by one, and xfer_done goes to 1 when it reaches 0. A burst that ends with words remaining sets early_end and keeps words_left, and the next rise of dev_rq opens a burst that continues the count.
- R8: Strobe changes that arrive after words_left has reached 0 store nothing and never appear at buf_data.
- R9: A strobe change on every clock cycle is accepted with no word lost.
- R10: Words that arrive after host_ready falls are all stored without buffer overflow and later delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load cfg_words into the word counter (taken in idle only) |
| cfg_words | input | CW (16) | Words expected for the command |
| cfg_wait | input | WW (8) | Clocks to wait between ready negation and STOP on a host-ended burst |
| cfg_thresh | input | LW (5) | Free-entry level at or below which ready is lowered |
| end_req | input | 1 | One-cycle request to end the current burst from the host side |
| dev_rq | input | 1 | Device DMA request |
| dev_strobe | input | 1 | Device data strobe |
| dev_data | input | DW (16) | Data word from the device |
| host_ready | output | 1 | Host ready for data |
| host_stop | output | 1 | Host STOP line |
| buf_rd | input | 1 | Read one word from the buffer |
| buf_data | output | DW (16) | Word read out of the buffer |
| buf_valid | output | 1 | buf_data holds a word, one cycle after buf_rd |
| buf_empty | output | 1 | Buffer is empty |
| words_left | output | CW (16) | Words still expected for the command |
| xfer_done | output | 1 | Word count has reached zero |
| early_end | output | 1 | A burst ended with words still outstanding |

## Verification
The data path gets four strobe patterns. Slow spaced toggles starting from a high idle level show whether the first level is wrongly taken as data. A toggle on every clock exposes lost or doubled edges. A long stall with the request held separates a pause from a false end. A stream driven only while ready is high, with reads held off, shows whether in-flight words are kept and whether ready really falls at the threshold. The scoreboard's ordered queue tells a dropped word from a misordered or extra one, and extra toggles after the count runs out must produce no output at all. Host-ended and device-ended bursts are timed at the STOP pin, so a wrong wait length can be told apart from a wrong acknowledgement order.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BURST = 3'd1,
    ST_PAUSE = 3'd2,
    ST_HSTOP = 3'd3,
    ST_DSTOP = 3'd4
  } rx_state_t;
endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/udma_rx_fifo.sv
module udma_rx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic do_wr, do_rd;

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign level = cnt;
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      cnt      <= cnt + LW'(do_wr) - LW'(do_rd);
      rd_valid <= do_rd;
    end
  end

  // R10: flow control must keep writes away from a full buffer
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
endmodule

// File: rtl/udma_rx_fsm.sv
module udma_rx_fsm
  import udma_rx_pkg::*;
#(
  parameter int CW = 16,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_words,
  input  logic [WW-1:0] cfg_wait,
  input  logic          end_req,
  input  logic          rq_s,
  input  logic          tog,
  input  logic          free_ok,
  output logic          wr_en,
  output logic          host_ready,
  output logic          host_stop,
  output logic [CW-1:0] words_left,
  output logic          xfer_done,
  output logic          early_end
);
  rx_state_t     state, nstate;
  logic [WW-1:0] wcnt;
  logic          term_pend;
  logic          active;
  logic          leaving;
  logic [CW-1:0] left_after;

  assign active     = (state == ST_BURST) || (state == ST_PAUSE) || (state == ST_HSTOP);
  assign wr_en      = tog && active && (words_left != '0);
  assign left_after = words_left - CW'(wr_en);
  assign leaving    = (nstate == ST_IDLE) && (state != ST_IDLE);

  always_comb begin
    nstate = state;
    case (state)
      ST_IDLE:  if (rq_s && words_left != '0 && !cfg_load) nstate = ST_BURST;
      ST_BURST: begin
        if (!rq_s)                                nstate = ST_DSTOP;
        else if (term_pend || words_left == '0)   nstate = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (!rq_s)            nstate = ST_DSTOP;
        else if (wcnt == '0)  nstate = ST_HSTOP;
      end
      ST_HSTOP: if (!rq_s) nstate = ST_IDLE;
      ST_DSTOP: nstate = ST_IDLE;
      default:  nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wcnt       <= '0;
      term_pend  <= 1'b0;
      words_left <= '0;
      xfer_done  <= 1'b0;
      early_end  <= 1'b0;
      host_ready <= 1'b0;
      host_stop  <= 1'b0;
    end else begin
      state      <= nstate;
      host_ready <= (nstate == ST_BURST) && free_ok;
      host_stop  <= (nstate == ST_HSTOP) || (nstate == ST_DSTOP);

      if (nstate == ST_PAUSE && state != ST_PAUSE) wcnt <= cfg_wait;
      else if (state == ST_PAUSE && wcnt != '0)    wcnt <= wcnt - 1'b1;

      if (cfg_load && state == ST_IDLE) begin
        words_left <= cfg_words;
        xfer_done  <= 1'b0;
        early_end  <= 1'b0;
        term_pend  <= 1'b0;
      end else begin
        words_left <= left_after;
        if (wr_en && words_left == CW'(1)) xfer_done <= 1'b1;
        if (leaving)      term_pend <= 1'b0;
        else if (end_req) term_pend <= 1'b1;
        if (leaving && left_after != '0) early_end <= 1'b1;
      end
    end
  end

  // R5: a host-side STOP (request still present) only follows a paused cycle
  assert_stop_after_pause_R5: assert property (@(posedge clk) disable iff (rst)
    (rq_s && $rose(host_stop)) |-> !$past(host_ready));

  // R6: request withdrawn during a burst or pause is confirmed by STOP
  assert_dev_end_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (((state == ST_BURST) || (state == ST_PAUSE)) && !rq_s) |=> host_stop);

  // R7: outside a load the count only ever steps down by one
  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_load) && words_left != $past(words_left))
      |-> words_left == $past(words_left) - CW'(1));

  // R7: done only with nothing left
  assert_done_zero_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> words_left == '0);
endmodule

// File: rtl/udma_rx_ctrl.sv
module udma_rx_ctrl #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int WW    = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_words,
  input  logic [WW-1:0] cfg_wait,
  input  logic [LW-1:0] cfg_thresh,
  input  logic          end_req,
  input  logic          dev_rq,
  input  logic          dev_strobe,
  input  logic [DW-1:0] dev_data,
  output logic          host_ready,
  output logic          host_stop,
  input  logic          buf_rd,
  output logic [DW-1:0] buf_data,
  output logic          buf_valid,
  output logic          buf_empty,
  output logic [CW-1:0] words_left,
  output logic          xfer_done,
  output logic          early_end
);
  logic [DW+1:0] smp;
  logic          rq_s, stb_s, stb_q, tog;
  logic [DW-1:0] dat_s;
  logic          wr_en, free_ok, buf_full;
  logic [LW-1:0] level, free;

  // data rides the same two stages as the strobe so both stay aligned
  udma_sync #(.W(DW + 2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dev_rq, dev_strobe, dev_data}),
    .q   (smp)
  );

  assign rq_s  = smp[DW+1];
  assign stb_s = smp[DW];
  assign dat_s = smp[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb_s;
  end

  assign tog     = stb_s ^ stb_q;
  assign free    = LW'(DEPTH) - level;
  assign free_ok = free > cfg_thresh;

  udma_rx_fsm #(.CW(CW), .WW(WW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cfg_load   (cfg_load),
    .cfg_words  (cfg_words),
    .cfg_wait   (cfg_wait),
    .end_req    (end_req),
    .rq_s       (rq_s),
    .tog        (tog),
    .free_ok    (free_ok),
    .wr_en      (wr_en),
    .host_ready (host_ready),
    .host_stop  (host_stop),
    .words_left (words_left),
    .xfer_done  (xfer_done),
    .early_end  (early_end)
  );

  udma_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (dat_s),
    .rd_en    (buf_rd),
    .rd_data  (buf_data),
    .rd_valid (buf_valid),
    .empty    (buf_empty),
    .full     (buf_full),
    .level    (level)
  );

  // R2: ready never rises unless space was above the threshold
  assert_ready_space_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(host_ready) |-> !$past(buf_full));
endmodule

// File: tb/udma_rx_ctrl_tb.sv
module udma_rx_ctrl_tb;
  localparam int DW = 16, DEPTH = 16, CW = 16, WW = 8;
  localparam int LW = $clog2(DEPTH) + 1;

  logic          clk = 0, rst = 1;
  logic          cfg_load = 0, end_req = 0, dev_rq = 0, dev_strobe = 1, buf_rd = 0;
  logic [CW-1:0] cfg_words = '0;
  logic [WW-1:0] cfg_wait = '0;
  logic [LW-1:0] cfg_thresh = '0;
  logic [DW-1:0] dev_data = '0;
  logic          host_ready, host_stop, buf_valid, buf_empty, xfer_done, early_end;
  logic [DW-1:0] buf_data;
  logic [CW-1:0] words_left;

  int checks = 0, fails = 0;
  bit mon_en = 0, finished = 0;
  logic [DW-1:0] exp_q [$];

  always #5 clk = ~clk;

  udma_rx_ctrl #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .WW(WW)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_words(cfg_words),
    .cfg_wait(cfg_wait), .cfg_thresh(cfg_thresh), .end_req(end_req),
    .dev_rq(dev_rq), .dev_strobe(dev_strobe), .dev_data(dev_data),
    .host_ready(host_ready), .host_stop(host_stop), .buf_rd(buf_rd),
    .buf_data(buf_data), .buf_valid(buf_valid), .buf_empty(buf_empty),
    .words_left(words_left), .xfer_done(xfer_done), .early_end(early_end)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one strobe change carrying one word, expected value queued
  task automatic send(input logic [DW-1:0] d, input int gap);
    @(negedge clk);
    dev_strobe = ~dev_strobe;
    dev_data   = d;
    exp_q.push_back(d);
    repeat (gap) @(negedge clk);
  endtask

  task automatic toggle_only(input logic [DW-1:0] d);
    @(negedge clk);
    dev_strobe = ~dev_strobe;
    dev_data   = d;
  endtask

  task automatic load(input int n, input int w, input int th);
    @(negedge clk);
    cfg_words = CW'(n); cfg_wait = WW'(w); cfg_thresh = LW'(th);
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic wait_level(input bit which_stop, input bit lvl, input int lim, output int n);
    n = 0;
    while (((which_stop ? host_stop : host_ready) != lvl) && n < lim) begin
      @(negedge clk); n++;
    end
  endtask

  // monitor: pops the scoreboard whenever the buffer hands out a word
  initial begin
    forever begin
      @(negedge clk);
      if (buf_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R8 unexpected word actual=%0d expected=none", buf_data);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          if (buf_data != e) begin
            fails++;
            $display("FAIL R3 word order actual=%0h expected=%0h", buf_data, e);
          end
        end
      end
      buf_rd = mon_en && !buf_empty;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 host_ready", host_ready, 0);
    chk("R1 host_stop", host_stop, 0);
    chk("R1 xfer_done", xfer_done, 0);
    chk("R1 early_end", early_end, 0);
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 words_left", words_left, 0);

    // ---- burst A: slow words, count runs out, host-ended, extras ignored
    mon_en = 1;
    load(4, 5, 4);
    dev_rq = 1;
    repeat (6) @(negedge clk);
    chk("R2 ready in burst", host_ready, 1);
    chk("R3 idle level not data words_left", words_left, 4);
    chk("R3 idle level not data empty", buf_empty, 1);
    send(16'hA001, 3); send(16'h5A02, 3); send(16'hA003, 3);
    send(16'h0F04, 0);
    toggle_only(16'hDEAD); toggle_only(16'hBEEF);   // R8 extras
    wait_level(1, 1, 40, n);
    chk("R5 stop after count done", host_stop, 1);
    chk("R5 ready low at stop", host_ready, 0);
    chk("R7 done", xfer_done, 1);
    chk("R7 words_left zero", words_left, 0);
    repeat (4) @(negedge clk);
    chk("R5 stop held while rq", host_stop, 1);
    dev_rq = 0;
    repeat (5) @(negedge clk);
    chk("R5 stop released", host_stop, 0);
    repeat (10) @(negedge clk);
    chk("R8 no extra words queued", exp_q.size(), 0);
    chk("R8 buffer empty", buf_empty, 1);
    chk("R7 no early end", early_end, 0);

    // ---- burst B: stall, device-ended early, resume at full rate
    load(6, 5, 4);
    dev_rq = 1;
    wait_level(0, 1, 10, n);
    send(16'h1111, 2); send(16'h2222, 2);
    ok = 1;
    repeat (40) begin
      @(negedge clk);
      if (!host_ready || host_stop) ok = 0;
    end
    chk("R4 stall keeps burst open", ok, 1);
    dev_rq = 0;
    wait_level(1, 1, 8, n);
    chk("R6 stop confirms device end", host_stop, 1);
    repeat (2) @(negedge clk);
    chk("R6 stop released", host_stop, 0);
    chk("R7 early_end set", early_end, 1);
    chk("R7 words kept", words_left, 4);
    dev_rq = 1;
    wait_level(0, 1, 10, n);
    chk("R7 new burst ready", host_ready, 1);
    send(16'h3333, 0); send(16'hCCCC, 0); send(16'h5555, 0); send(16'hAAAA, 0);
    wait_level(1, 1, 40, n);
    chk("R9 all fast words counted", words_left, 0);
    chk("R9 done", xfer_done, 1);
    dev_rq = 0;
    repeat (12) @(negedge clk);
    chk("R9 fast words delivered", exp_q.size(), 0);

    // ---- burst C: host end request, wait timing
    load(10, 7, 4);
    dev_rq = 1;
    wait_level(0, 1, 10, n);
    send(16'h0101, 2); send(16'h0202, 2); send(16'h0303, 4);
    @(negedge clk); end_req = 1;
    @(negedge clk); end_req = 0;
    wait_level(0, 0, 10, n);
    chk("R5 ready falls on end_req", host_ready, 0);
    chk("R5 no stop before wait", host_stop, 0);
    wait_level(1, 1, 30, n);
    chk("R5 stop delay cfg_wait+1", n, 8);
    dev_rq = 0;
    repeat (5) @(negedge clk);
    chk("R5 stop dropped", host_stop, 0);
    chk("R7 early_end after host end", early_end, 1);
    chk("R7 words kept after host end", words_left, 7);

    // ---- burst D: threshold pause with words in flight
    repeat (10) @(negedge clk);
    mon_en = 0;
    load(20, 3, 6);
    dev_rq = 1;
    wait_level(0, 1, 10, n);
    begin
      int sent = 0;
      bit saw_low = 0;
      while (sent < 20) begin
        @(negedge clk);
        if (host_ready) begin
          dev_strobe = ~dev_strobe;
          dev_data   = DW'(16'h7000 + sent);
          exp_q.push_back(dev_data);
          sent++;
        end else if (!saw_low) begin
          saw_low = 1;
          ok = 1;
          repeat (5) begin
            @(negedge clk);
            if (host_ready) ok = 0;
          end
          chk("R2 ready held low near full", ok, 1);
          mon_en = 1;
        end
      end
      chk("R2 pause seen before end", saw_low, 1);
    end
    wait_level(1, 1, 60, n);
    chk("R10 all words counted", words_left, 0);
    dev_rq = 0;
    repeat (30) @(negedge clk);
    chk("R10 all words delivered", exp_q.size(), 0);
    chk("R10 buffer drained", buf_empty, 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule